// File: doc/BRIEF.md
# Slow-Tick Deferred Register Write Unit

This block is the host-facing register front end of a real-time-clock peripheral. A host on the fast bus clock writes the time, alarm, stopwatch, interrupt-enable and prescaler-enable registers. None of these writes takes effect at once. The address and data go into a single holding slot, and they are committed on the next rising edge of a slow once-per-second tick. That tick is brought into the bus clock domain through a two-flop stage and an edge detector.

While the slot is occupied, any further write to a deferred register is thrown away without effect. Software must therefore poll the status register. It shows a pending bit while the slot is occupied, and a sticky done bit after a commit that software acknowledges by writing 1. The status register is not deferred. It also holds event flags raised by the rest of the peripheral, and writes to it clear flags directly on the bus clock. Reads always return committed register contents.

Top module: `rtc_wr_defer`

## Requirements
- R1: After reset every register reads 0, including the status word, and no write is pending.
- R2: Address map: 0 time (32 bits), 1 alarm (32 bits), 2 stopwatch (low 16 bits), 3 interrupt enable (low 16 bits), 4 prescaler enable (bit 0), 5 status. The status word is laid out as follows: bit 15 is done, bit 14 is pending, and bits 13:0 are event flags. The upper bits of narrower registers read 0.
- R3: A bus write to addresses 0 to 4 with no write held makes status bit 14 read 1 from the next cycle on.
- R4: A held write commits to its register two bus clocks after the tick input rises, counting the two synchronizer flops. From that point bit 14 reads 0 and bit 15 reads 1.
- R5: While a write is held, any further write to addresses 0 to 4 is discarded. Only the first held value is committed, and no other register changes.
- R6: Writing status with bit 15 set clears bit 15 on the next cycle. Writing status with bit 15 clear leaves bit 15 unchanged.
- R7: A pulse on an event input sets the matching status flag. Writing 1 to a flag bit clears it on the next cycle, and writing 0 leaves it. Status writes are never held and never set pending, even while another write is held.
- R8: A read of a deferred register returns the committed value, never the held one.
- R9: A tick held high commits only once. A write made while the tick stays high waits for the next rising edge.
- R10: Writes to addresses 6 and 7 are ignored: nothing becomes pending, and those addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_waddr | input | 3 | Write address |
| bus_wdata | input | 32 | Write data |
| bus_raddr | input | 3 | Read address |
| bus_rdata | output | 32 | Read data (combinational) |
| tick_async | input | 1 | Slow tick, asynchronous to clk |
| evt_set | input | 14 | Event flag set pulses |
| time_val | output | 32 | Committed time register |
| alarm_val | output | 32 | Committed alarm register |
| swcnt_val | output | 16 | Committed stopwatch register |
| irq_en | output | 16 | Committed interrupt enable mask |
| pren | output | 1 | Committed prescaler enable |

## Verification
The bench drives a second and a third write into an occupied slot, including one aimed at a different register. A design that overwrote the slot would commit the last value, and one that merged writes would change a register that should not move. It reads back registers while a write is held, which catches a read path that forwards the held data. It holds the tick high across a write, which catches a level-sensitive commit that would apply the write without a new edge. Status writes made while a write is held must clear flags at once without disturbing the pending write. Writes to bit 15 with 0 and with 1 show whether the done bit clears on acknowledge only.

// File: rtl/rtcw_pkg.sv
package rtcw_pkg;
    localparam int ADDR_W   = 3;
    localparam int DATA_W   = 32;
    localparam int STAT_W   = 16;
    localparam int EVT_W    = 14;
    localparam int BIT_DONE = 15;
    localparam int BIT_PEND = 14;

    typedef enum logic [ADDR_W-1:0] {
        A_TIME  = 3'd0,
        A_ALARM = 3'd1,
        A_SWCNT = 3'd2,
        A_IRQEN = 3'd3,
        A_PREN  = 3'd4,
        A_STAT  = 3'd5
    } reg_addr_e;

    function automatic logic is_deferred(input logic [ADDR_W-1:0] a);
        return a <= 3'd4;
    endfunction
endpackage

// File: rtl/tick_sync.sv
module tick_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_async,
    output logic tick_rise
);
    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[STAGES-2:0], tick_async};
        st_d.prev = st_q.sync[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick_rise = st_q.sync[STAGES-1] & ~st_q.prev;

    assert_rise_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tick_rise |=> !tick_rise);
endmodule

// File: rtl/hold_slot.sv
module hold_slot #(
    parameter int AW = 3,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_req,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          tick_rise,
    output logic          pending,
    output logic          commit,
    output logic [AW-1:0] commit_addr,
    output logic [DW-1:0] commit_data
);
    typedef struct packed {
        logic          pend;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } slot_t;

    slot_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.pend) begin
            // Held write: commit on tick edge; incoming writes are dropped.
            if (tick_rise) st_d.pend = 1'b0;
        end else if (wr_req) begin
            st_d.pend = 1'b1;
            st_d.addr = wr_addr;
            st_d.data = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pending     = st_q.pend;
    assign commit      = st_q.pend & tick_rise;
    assign commit_addr = st_q.addr;
    assign commit_data = st_q.data;

    assert_held_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !tick_rise) |=> pending && $stable(commit_addr) && $stable(commit_data));
    assert_commit_frees_R4: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !pending);
    assert_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!pending && wr_req) |=> pending);
endmodule

// File: rtl/status_reg.sv
module status_reg #(
    parameter int EW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          commit,
    input  logic          pending,
    input  logic          wr,
    input  logic [15:0]   wdata,
    input  logic [EW-1:0] evt_set,
    output logic [15:0]   stat_word
);
    typedef struct packed {
        logic          done;
        logic [EW-1:0] evt;
    } stat_t;

    stat_t st_d, st_q;
    logic  unused_wbit;

    assign unused_wbit = wdata[14];

    always_comb begin
        st_d = st_q;
        if (wr) begin
            st_d.evt = st_q.evt & ~wdata[EW-1:0];
            if (wdata[15]) st_d.done = 1'b0;
        end
        st_d.evt = st_d.evt | evt_set;
        if (commit) st_d.done = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat_word = {st_q.done, pending, st_q.evt};

    assert_done_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> stat_word[15]);
    assert_done_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_word[15] && !(wr && wdata[15])) |=> stat_word[15]);
    assert_evt_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_set) |=> ((stat_word[EW-1:0] & $past(evt_set)) == $past(evt_set)));
endmodule

// File: rtl/rtc_wr_defer.sv
module rtc_wr_defer
    import rtcw_pkg::*;
#(
    parameter int SW_W  = 16,
    parameter int IRQ_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_waddr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [ADDR_W-1:0] bus_raddr,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              tick_async,
    input  logic [EVT_W-1:0]  evt_set,
    output logic [DATA_W-1:0] time_val,
    output logic [DATA_W-1:0] alarm_val,
    output logic [SW_W-1:0]   swcnt_val,
    output logic [IRQ_W-1:0]  irq_en,
    output logic              pren
);
    typedef struct packed {
        logic [DATA_W-1:0] tm;
        logic [DATA_W-1:0] alarm;
        logic [SW_W-1:0]   swcnt;
        logic [IRQ_W-1:0]  irqen;
        logic              pren;
    } regs_t;

    regs_t rg_d, rg_q;

    logic              tick_rise, pending, commit;
    logic [ADDR_W-1:0] c_addr;
    logic [DATA_W-1:0] c_data;
    logic [STAT_W-1:0] stat_word;
    logic              slot_wr, stat_wr;

    assign slot_wr = bus_wr && is_deferred(bus_waddr);
    assign stat_wr = bus_wr && (bus_waddr == A_STAT);

    tick_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .tick_async(tick_async), .tick_rise(tick_rise)
    );

    hold_slot #(.AW(ADDR_W), .DW(DATA_W)) u_slot (
        .clk(clk), .rst_n(rst_n), .wr_req(slot_wr), .wr_addr(bus_waddr),
        .wr_data(bus_wdata), .tick_rise(tick_rise), .pending(pending),
        .commit(commit), .commit_addr(c_addr), .commit_data(c_data)
    );

    status_reg #(.EW(EVT_W)) u_stat (
        .clk(clk), .rst_n(rst_n), .commit(commit), .pending(pending),
        .wr(stat_wr), .wdata(bus_wdata[STAT_W-1:0]), .evt_set(evt_set),
        .stat_word(stat_word)
    );

    always_comb begin
        rg_d = rg_q;
        if (commit) begin
            case (c_addr)
                A_TIME:  rg_d.tm    = c_data;
                A_ALARM: rg_d.alarm = c_data;
                A_SWCNT: rg_d.swcnt = c_data[SW_W-1:0];
                A_IRQEN: rg_d.irqen = c_data[IRQ_W-1:0];
                A_PREN:  rg_d.pren  = c_data[0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    always_comb begin
        case (bus_raddr)
            A_TIME:  bus_rdata = rg_q.tm;
            A_ALARM: bus_rdata = rg_q.alarm;
            A_SWCNT: bus_rdata = DATA_W'(rg_q.swcnt);
            A_IRQEN: bus_rdata = DATA_W'(rg_q.irqen);
            A_PREN:  bus_rdata = DATA_W'(rg_q.pren);
            A_STAT:  bus_rdata = DATA_W'(stat_word);
            default: bus_rdata = '0;
        endcase
    end

    assign time_val  = rg_q.tm;
    assign alarm_val = rg_q.alarm;
    assign swcnt_val = rg_q.swcnt;
    assign irq_en    = rg_q.irqen;
    assign pren      = rg_q.pren;

    assert_hold_regs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(rg_q));
    assert_stat_not_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && !pending) |=> !pending);
    assert_unused_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_waddr > 3'd5 && !pending) |=> !pending);
endmodule

// File: tb/sim_rtc_wr_defer.sv
module sim_rtc_wr_defer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_waddr = '0;
    logic [31:0] bus_wdata = '0;
    logic [2:0]  bus_raddr = '0;
    logic [31:0] bus_rdata;
    logic        tick_async = 1'b0;
    logic [13:0] evt_set = '0;
    logic [31:0] time_val, alarm_val;
    logic [15:0] swcnt_val, irq_en;
    logic        pren;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    rtc_wr_defer u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_waddr(bus_waddr),
        .bus_wdata(bus_wdata), .bus_raddr(bus_raddr), .bus_rdata(bus_rdata),
        .tick_async(tick_async), .evt_set(evt_set), .time_val(time_val),
        .alarm_val(alarm_val), .swcnt_val(swcnt_val), .irq_en(irq_en), .pren(pren)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_waddr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [2:0] a, input logic [31:0] exp);
        bus_raddr = a;
        #1;
        chk(req, bus_rdata, exp);
    endtask

    task automatic tick();
        @(negedge clk); tick_async = 1'b1;
        repeat (4) @(negedge clk);
        tick_async = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        for (int a = 0; a < 8; a++) rd_chk("R1 reset", 3'(a), 32'h0);
    endtask

    task automatic t_basic();
        wr(3'd0, 32'h1234_5678);
        rd_chk("R3 pending set", 3'd5, 32'h0000_4000);
        rd_chk("R8 committed read", 3'd0, 32'h0);
        repeat (5) @(negedge clk);
        rd_chk("R8 still committed", 3'd0, 32'h0);
        tick();
        rd_chk("R4 committed", 3'd0, 32'h1234_5678);
        chk("R4 time port", time_val, 32'h1234_5678);
        rd_chk("R4 done flag", 3'd5, 32'h0000_8000);
        wr(3'd5, 32'h0000_0000);
        rd_chk("R6 zero keeps done", 3'd5, 32'h0000_8000);
        wr(3'd5, 32'h0000_8000);
        rd_chk("R6 ack clears done", 3'd5, 32'h0);
    endtask

    task automatic t_drop();
        wr(3'd1, 32'hAAAA_0001);
        wr(3'd3, 32'h0000_00FF);
        wr(3'd1, 32'hBBBB_0002);
        tick();
        rd_chk("R5 first kept", 3'd1, 32'hAAAA_0001);
        rd_chk("R5 other untouched", 3'd3, 32'h0);
        rd_chk("R5 slot free", 3'd5, 32'h0000_8000);
        wr(3'd5, 32'h0000_8000);
    endtask

    task automatic t_widths();
        wr(3'd2, 32'hFFFF_ABCD); tick();
        rd_chk("R2 stopwatch width", 3'd2, 32'h0000_ABCD);
        wr(3'd4, 32'hFFFF_FFFF); tick();
        rd_chk("R2 prescaler bit", 3'd4, 32'h1);
        chk("R2 pren port", {31'h0, pren}, 32'h1);
        wr(3'd3, 32'hDEAD_1234); tick();
        rd_chk("R2 irq enable width", 3'd3, 32'h0000_1234);
        wr(3'd5, 32'h0000_8000);
        wr(3'd6, 32'h5555_5555);
        wr(3'd7, 32'h6666_6666);
        rd_chk("R10 no pending", 3'd5, 32'h0);
        rd_chk("R10 reads zero", 3'd6, 32'h0);
    endtask

    task automatic t_events();
        @(negedge clk); evt_set = 14'h0005;
        @(negedge clk); evt_set = '0;
        rd_chk("R7 flags set", 3'd5, 32'h0000_0005);
        wr(3'd5, 32'h0000_0001);
        rd_chk("R7 w1c one flag", 3'd5, 32'h0000_0004);
        wr(3'd0, 32'h0000_0777);
        wr(3'd5, 32'h0000_0004);
        rd_chk("R7 clear while held", 3'd5, 32'h0000_4000);
        tick();
        rd_chk("R7 held write survives", 3'd0, 32'h0000_0777);
        wr(3'd5, 32'h0000_8000);
    endtask

    task automatic t_level();
        wr(3'd0, 32'h0000_1111);
        @(negedge clk); tick_async = 1'b1;
        repeat (4) @(negedge clk);
        rd_chk("R9 first commit", 3'd0, 32'h0000_1111);
        wr(3'd5, 32'h0000_8000);
        wr(3'd0, 32'h0000_2222);
        repeat (6) @(negedge clk);
        rd_chk("R9 no commit on level", 3'd0, 32'h0000_1111);
        rd_chk("R9 still pending", 3'd5, 32'h0000_4000);
        tick_async = 1'b0;
        repeat (3) @(negedge clk);
        tick();
        rd_chk("R9 next edge commits", 3'd0, 32'h0000_2222);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_drop();
        t_widths();
        t_events();
        t_level();
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        #500000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule